// File: doc/BRIEF.md
# Prefetch Candidate Queue Manager

This block holds hardware prefetch requests that are waiting to go out to memory. It sits beside a cache controller. An external address generator hands it candidate addresses, one per cycle. Each candidate carries a delay that is measured from the most recent accepted demand miss. Before a candidate is admitted, the block checks it against three things: blocks already pending in the miss-status registers, blocks already present in the cache (when that check is done at insert time), and its own contents. A candidate that survives is appended at the tail. If the queue is full, the oldest entry is pushed out to make room.

A demand miss can cancel queued work. If the miss block is already queued, that entry is deleted. When serial squashing is configured, the miss also trims the tail: entries are removed from the tail while their ready time is not earlier than the miss timestamp. The memory-side arbiter asks for the next prefetch with a one-cycle issue request. In the configuration that checks the cache at issue time, the block discards head entries that hit in the cache, one per cycle, until it finds one to issue or the queue is empty. It then reports either an address or "nothing". A bus request line follows queue occupancy, and it carries the ready time of the most recent insert. Eight event counters record what happened to each candidate and entry.

Top module: `pfq_mgr`

## Requirements
- R1: Every address is reduced to its block address by clearing its low log2(BLK_BYTES) bits. Matching between queue entries, misses and candidates is done on block addresses, and `pf_addr` and `head_addr` always have those low bits at zero.
- R2: A demand miss with `miss_uncache` set is ignored entirely, and so is a miss with `miss_ifetch` set when DATA_ONLY is 1. An ignored miss removes no entry, squashes nothing and does not change the time base used for later candidates.
- R3: An accepted miss whose block matches a queued entry deletes that entry and adds one to counter 5.
- R4: With SQUASH_EN=1, an accepted miss removes entries from the tail while the tail entry's ready time is greater than or equal to `miss_time`. The search stops at the first entry that is earlier. Each removed entry adds one to counter 6. With SQUASH_EN=0, no entry is ever squashed.
- R5: An inserted candidate gets a ready time equal to the time base plus `cand_delay`, modulo 2^TW. The time base is `miss_time` when a miss is accepted in the same cycle, and otherwise the timestamp of the last accepted miss (0 after reset). `bus_time` shows the ready time of the most recent insert.
- R6: A handshaken candidate is dropped, and not inserted, on the first of these conditions that holds: (a) CHECK_AT_INSERT=1 and `cand_in_cache`, counted in counter 2; (b) `cand_in_mshr`, counted in counter 1; (c) its block is already queued, counted in counter 3.
- R7: Inserting into a full queue (DEPTH entries) first discards the head entry and adds one to counter 4. Occupancy never exceeds DEPTH.
- R8: An issue request pops the head. With CHECK_AT_INSERT=0, a popped head for which `head_cached` is high is discarded instead, adding one to counter 2, and the next head is examined in the following cycle. The result is one pulse: either `pf_valid` with `pf_addr`, which also adds one to counter 7, or `pf_none` when the queue is empty.
- R9: `bus_req` is high exactly when the queue is non-empty, updated in the cycle after each change.
- R10: The counter indices in `ev_cnt` are: 0 candidates handshaken, 1 already pending in the miss registers, 2 already cached, 3 already queued, 4 evicted because the queue was full, 5 removed by a miss, 6 squashed, 7 issued.
- R11: In a cycle that has both an accepted miss and a candidate, the miss's removal and squash are applied first, and then the insert is made against the reduced queue. An issue step does not run in a cycle with an accepted miss. `cand_ready` is low from the issue request until the issue result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Demand-miss notification valid |
| miss_addr | input | AW | Demand-miss byte address |
| miss_time | input | TW | Demand-miss timestamp |
| miss_uncache | input | 1 | Miss is to an uncacheable location |
| miss_ifetch | input | 1 | Miss is an instruction fetch |
| cand_valid | input | 1 | Prefetch candidate valid |
| cand_ready | output | 1 | Candidate accepted this cycle when high |
| cand_addr | input | AW | Candidate byte address |
| cand_delay | input | DW | Candidate delay after the time base |
| cand_in_mshr | input | 1 | Lookup response: candidate block pending in miss registers |
| cand_in_cache | input | 1 | Lookup response: candidate block present in cache |
| head_addr | output | AW | Block address of the queue head, for the issue-time tag lookup |
| head_cached | input | 1 | Lookup response: head block present in cache |
| issue_req | input | 1 | Arbiter asks for the next prefetch |
| pf_valid | output | 1 | One-cycle pulse: `pf_addr` is the issued prefetch |
| pf_none | output | 1 | One-cycle pulse: issue request found nothing to issue |
| pf_addr | output | AW | Issued prefetch block address |
| bus_req | output | 1 | Memory-bus prefetch request |
| bus_time | output | TW | Earliest issue time for the request |
| ev_cnt | output | 8 x CW | Event counters, index order per R10 |

## Verification
Some properties are checked on every cycle: occupancy stays within bounds, `bus_req` agrees with occupancy, evictions happen only when the queue is full, an issue result never appears in a cycle right after an accepted miss, the two result pulses never coincide, a matching miss always bumps the removal counter, and an uncacheable miss on an otherwise idle cycle leaves occupancy unchanged. Other behaviours only the bench's scenarios can show, because each needs a whole history to judge. These are the drop priority, the ready-time arithmetic, the exact length of a tail squash, which entry an eviction discards, and which address the issue scan finally returns. The bench checks them by replaying a long pseudo-random sequence of misses, candidates and issue requests on two opposite option sets against an arithmetic model of the queue.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  localparam int NUM_EV = 8;

  typedef enum logic [2:0] {
    EV_IDENT  = 3'd0,
    EV_MSHR   = 3'd1,
    EV_CACHE  = 3'd2,
    EV_QUEUE  = 3'd3,
    EV_EVICT  = 3'd4,
    EV_REMOVE = 3'd5,
    EV_SQUASH = 3'd6,
    EV_ISSUE  = 3'd7
  } pfq_ev_e;

endpackage

// File: rtl/pfq_store.sv
// Ordered entry store: index 0 is the oldest entry. Each cycle the surviving
// entries are compacted toward index 0, then an optional append is made.
module pfq_store #(
  parameter int DEPTH     = 8,
  parameter int BW        = 26,
  parameter int TW        = 32,
  parameter int CNTW      = 4,
  parameter bit SQUASH_EN = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            miss_go,
  input  logic [BW-1:0]   miss_blk,
  input  logic [TW-1:0]   miss_time,
  input  logic            pop_head,
  input  logic            ins_go,
  input  logic [BW-1:0]   ins_blk,
  input  logic [TW-1:0]   ins_time,
  output logic [BW-1:0]   head_blk,
  output logic [CNTW-1:0] q_count,
  output logic [CNTW-1:0] nxt_count,
  output logic            dup_hit,
  output logic            rm_hit,
  output logic [CNTW-1:0] sq_num,
  output logic            full_kept
);

  logic [BW-1:0]   v_addr [DEPTH];
  logic [TW-1:0]   v_time [DEPTH];
  logic [CNTW-1:0] cnt_q;

  logic [DEPTH-1:0] live, hit_m, keep1, sq, keep3, match_c;
  logic [BW-1:0]    c_addr [DEPTH];
  logic [TW-1:0]    c_time [DEPTH];
  logic [BW-1:0]    n_addr [DEPTH];
  logic [TW-1:0]    n_time [DEPTH];
  logic [CNTW-1:0]  kept_n, n_cnt;

  function automatic logic at_or_after(input logic [TW-1:0] rdy,
                                       input logic [TW-1:0] stamp);
    return rdy >= stamp;
  endfunction

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      assign live[g]    = (CNTW'(g) < cnt_q);
      assign hit_m[g]   = miss_go & live[g] & (v_addr[g] == miss_blk);
      assign keep1[g]   = live[g] & ~hit_m[g];
      assign match_c[g] = (v_addr[g] == ins_blk);
    end
  endgenerate

  // tail squash: walk from the youngest kept entry while ready >= miss time
  always_comb begin
    logic run;
    run = 1'b1;
    sq  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (keep1[i]) begin
        if (run && SQUASH_EN && miss_go && at_or_after(v_time[i], miss_time))
          sq[i] = 1'b1;
        else
          run = 1'b0;
      end
    end
  end

  assign keep3 = keep1 & ~sq & ~(DEPTH'(pop_head));

  // compaction of survivors toward index 0
  always_comb begin
    int k;
    k = 0;
    for (int j = 0; j < DEPTH; j++) begin
      c_addr[j] = '0;
      c_time[j] = '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (keep3[i]) begin
        c_addr[k] = v_addr[i];
        c_time[k] = v_time[i];
        k++;
      end
    end
    kept_n = CNTW'(k);
  end

  assign full_kept = (kept_n == CNTW'(DEPTH));

  // append, discarding the oldest survivor when full
  always_comb begin
    n_addr = c_addr;
    n_time = c_time;
    n_cnt  = kept_n;
    if (ins_go) begin
      if (full_kept) begin
        for (int j = 0; j < DEPTH - 1; j++) begin
          n_addr[j] = c_addr[j+1];
          n_time[j] = c_time[j+1];
        end
        n_addr[DEPTH-1] = ins_blk;
        n_time[DEPTH-1] = ins_time;
      end else begin
        for (int j = 0; j < DEPTH; j++) begin
          if (CNTW'(j) == kept_n) begin
            n_addr[j] = ins_blk;
            n_time[j] = ins_time;
          end
        end
        n_cnt = kept_n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int j = 0; j < DEPTH; j++) begin
        v_addr[j] <= '0;
        v_time[j] <= '0;
      end
    end else begin
      cnt_q <= n_cnt;
      for (int j = 0; j < DEPTH; j++) begin
        v_addr[j] <= n_addr[j];
        v_time[j] <= n_time[j];
      end
    end
  end

  assign head_blk  = v_addr[0];
  assign q_count   = cnt_q;
  assign nxt_count = n_cnt;
  assign dup_hit   = |(keep3 & match_c);
  assign rm_hit    = |hit_m;
  assign sq_num    = CNTW'($countones(sq));

endmodule

// File: rtl/pfq_counters.sv
module pfq_counters #(
  parameter int NEV = 8,
  parameter int CW  = 32,
  parameter int IW  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NEV-1:0][IW-1:0]  inc,
  output logic [NEV-1:0][CW-1:0]  cnt
);

  genvar g;
  generate
    for (g = 0; g < NEV; g++) begin : g_ev
      always_ff @(posedge clk) begin
        if (!rst_n) cnt[g] <= '0;
        else        cnt[g] <= cnt[g] + CW'(inc[g]);
      end
    end
  endgenerate

endmodule

// File: rtl/pfq_mgr.sv
module pfq_mgr
  import pfq_pkg::*;
#(
  parameter int AW              = 32,
  parameter int TW              = 32,
  parameter int DW              = 16,
  parameter int CW              = 32,
  parameter int DEPTH           = 8,
  parameter int BLK_BYTES       = 64,
  parameter bit CHECK_AT_INSERT = 1'b1,
  parameter bit SQUASH_EN       = 1'b0,
  parameter bit DATA_ONLY       = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      miss_valid,
  input  logic [AW-1:0]             miss_addr,
  input  logic [TW-1:0]             miss_time,
  input  logic                      miss_uncache,
  input  logic                      miss_ifetch,
  input  logic                      cand_valid,
  output logic                      cand_ready,
  input  logic [AW-1:0]             cand_addr,
  input  logic [DW-1:0]             cand_delay,
  input  logic                      cand_in_mshr,
  input  logic                      cand_in_cache,
  output logic [AW-1:0]             head_addr,
  input  logic                      head_cached,
  input  logic                      issue_req,
  output logic                      pf_valid,
  output logic                      pf_none,
  output logic [AW-1:0]             pf_addr,
  output logic                      bus_req,
  output logic [TW-1:0]             bus_time,
  output logic [NUM_EV-1:0][CW-1:0] ev_cnt
);

  localparam int OFFB = $clog2(BLK_BYTES);
  localparam int BW   = AW - OFFB;
  localparam int CNTW = $clog2(DEPTH + 1);

  function automatic logic [BW-1:0] blk_of(input logic [AW-1:0] a);
    return a[AW-1:OFFB];
  endfunction

  function automatic logic [AW-1:0] addr_of(input logic [BW-1:0] b);
    return {b, {OFFB{1'b0}}};
  endfunction

  function automatic logic [TW-1:0] ready_of(input logic [TW-1:0] base,
                                             input logic [DW-1:0] dly);
    return base + TW'(dly);
  endfunction

  // named internal events
  logic            miss_go, iss_act, iss_step, iss_done, pop, skip_hd, q_empty;
  logic            cand_go, drop_cache, drop_mshr, drop_dup, ins_go, evict_ev;
  logic            rm_hit, dup_hit, full_kept;
  logic [BW-1:0]   head_blk;
  logic [CNTW-1:0] q_count, nxt_count, sq_num;
  logic [TW-1:0]   base_time, cand_time;

  logic            iss_pend_q, pf_valid_q, pf_none_q, bus_req_q;
  logic [AW-1:0]   pf_addr_q;
  logic [TW-1:0]   bus_time_q, last_time_q;

  logic [NUM_EV-1:0][CNTW-1:0] ev_inc;

  logic unused_low;
  assign unused_low = ^{miss_addr[OFFB-1:0], cand_addr[OFFB-1:0]};

  assign miss_go  = miss_valid & ~miss_uncache & ~(DATA_ONLY & miss_ifetch);
  assign iss_act  = iss_pend_q | issue_req;
  assign iss_step = iss_act & ~miss_go;
  assign q_empty  = (q_count == '0);
  assign skip_hd  = ~CHECK_AT_INSERT & head_cached & ~q_empty;
  assign pop      = iss_step & ~q_empty;
  assign iss_done = iss_step & (q_empty | ~skip_hd);

  assign cand_ready = ~iss_act;
  assign cand_go    = cand_valid & cand_ready;
  assign drop_cache = CHECK_AT_INSERT & cand_in_cache;
  assign drop_mshr  = ~drop_cache & cand_in_mshr;
  assign drop_dup   = ~drop_cache & ~drop_mshr & dup_hit;
  assign ins_go     = cand_go & ~drop_cache & ~drop_mshr & ~dup_hit;
  assign evict_ev   = ins_go & full_kept;

  assign base_time = miss_go ? miss_time : last_time_q;
  assign cand_time = ready_of(base_time, cand_delay);

  pfq_store #(
    .DEPTH(DEPTH), .BW(BW), .TW(TW), .CNTW(CNTW), .SQUASH_EN(SQUASH_EN)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .miss_go(miss_go), .miss_blk(blk_of(miss_addr)), .miss_time(miss_time),
    .pop_head(pop),
    .ins_go(ins_go), .ins_blk(blk_of(cand_addr)), .ins_time(cand_time),
    .head_blk(head_blk), .q_count(q_count), .nxt_count(nxt_count),
    .dup_hit(dup_hit), .rm_hit(rm_hit), .sq_num(sq_num), .full_kept(full_kept)
  );

  assign ev_inc[EV_IDENT]  = CNTW'(cand_go);
  assign ev_inc[EV_MSHR]   = CNTW'(cand_go & drop_mshr);
  assign ev_inc[EV_CACHE]  = CNTW'((cand_go & drop_cache) | (pop & skip_hd));
  assign ev_inc[EV_QUEUE]  = CNTW'(cand_go & drop_dup);
  assign ev_inc[EV_EVICT]  = CNTW'(evict_ev);
  assign ev_inc[EV_REMOVE] = CNTW'(rm_hit);
  assign ev_inc[EV_SQUASH] = sq_num;
  assign ev_inc[EV_ISSUE]  = CNTW'(pop & ~skip_hd);

  pfq_counters #(.NEV(NUM_EV), .CW(CW), .IW(CNTW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(ev_inc), .cnt(ev_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_pend_q  <= 1'b0;
      pf_valid_q  <= 1'b0;
      pf_none_q   <= 1'b0;
      pf_addr_q   <= '0;
      bus_req_q   <= 1'b0;
      bus_time_q  <= '0;
      last_time_q <= '0;
    end else begin
      iss_pend_q <= iss_act & ~iss_done;
      pf_valid_q <= pop & ~skip_hd;
      pf_none_q  <= iss_step & q_empty;
      if (pop & ~skip_hd) pf_addr_q <= addr_of(head_blk);
      bus_req_q <= (nxt_count != '0);
      if (ins_go)  bus_time_q  <= cand_time;
      if (miss_go) last_time_q <= miss_time;
    end
  end

  assign head_addr = addr_of(head_blk);
  assign pf_valid  = pf_valid_q;
  assign pf_none   = pf_none_q;
  assign pf_addr   = pf_addr_q;
  assign bus_req   = bus_req_q;
  assign bus_time  = bus_time_q;

endmodule

// File: rtl/pfq_mgr_chk.sv
module pfq_mgr_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 32,
  parameter int CNTW  = 4,
  parameter int NEV   = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CNTW-1:0]        q_count,
  input logic                   miss_go,
  input logic                   miss_valid,
  input logic                   miss_uncache,
  input logic                   cand_valid,
  input logic                   iss_act,
  input logic                   ins_go,
  input logic                   rm_hit,
  input logic                   evict_ev,
  input logic                   pf_valid,
  input logic                   pf_none,
  input logic                   bus_req,
  input logic [NEV-1:0][CW-1:0] ev_cnt
);

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNTW'(DEPTH));

  // R7
  evict_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_ev |-> (q_count == CNTW'(DEPTH)) || miss_go);

  // R9
  bus_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req == (q_count != '0));

  // R9
  insert_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_go |=> bus_req);

  // R8
  pf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pf_valid && pf_none));

  // R11
  issue_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_go |=> !(pf_valid || pf_none));

  // R2
  ignore_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_uncache && !cand_valid && !iss_act)
      |=> q_count == $past(q_count));

  // R3
  remove_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rm_hit |=> ev_cnt[pfq_pkg::EV_REMOVE] == CW'($past(ev_cnt[pfq_pkg::EV_REMOVE]) + 1'b1));

endmodule

bind pfq_mgr pfq_mgr_chk #(
  .DEPTH(DEPTH), .CW(CW), .CNTW(CNTW), .NEV(pfq_pkg::NUM_EV)
) chk_i (
  .clk(clk), .rst_n(rst_n), .q_count(q_count), .miss_go(miss_go),
  .miss_valid(miss_valid), .miss_uncache(miss_uncache), .cand_valid(cand_valid),
  .iss_act(iss_act), .ins_go(ins_go), .rm_hit(rm_hit), .evict_ev(evict_ev),
  .pf_valid(pf_valid), .pf_none(pf_none), .bus_req(bus_req), .ev_cnt(ev_cnt)
);

// File: tb/pfq_mgr_tb_top.sv
module pfq_mgr_tb_top;
  import pfq_pkg::*;

  localparam int CLK_NS = 10;
  localparam int DEPTH  = 4;
  localparam int AW     = 16;
  localparam int TW     = 16;
  localparam int DW     = 8;
  localparam int CW     = 16;
  localparam int OFFB   = 4;
  localparam int NEV    = NUM_EV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic          miss_valid = 0, miss_uncache = 0, miss_ifetch = 0;
  logic [AW-1:0] miss_addr = '0;
  logic [TW-1:0] miss_time = '0;
  logic          cand_valid = 0, issue_req = 0;
  logic [AW-1:0] cand_addr = '0;
  logic [DW-1:0] cand_delay = '0;
  logic          cand_in_mshr, cand_in_cache;

  logic          crdy [2];
  logic [AW-1:0] hadr [2];
  logic          hcac [2];
  logic          pfv  [2];
  logic          pfn  [2];
  logic [AW-1:0] pfa  [2];
  logic          breq [2];
  logic [TW-1:0] btim [2];
  logic [NEV-1:0][CW-1:0] evc [2];

  function automatic logic cached_blk(input int b);
    return (b % 5) == 3;
  endfunction
  function automatic logic mshr_blk(input int b);
    return (b % 7) == 6;
  endfunction

  assign cand_in_cache = cached_blk(int'(cand_addr >> OFFB));
  assign cand_in_mshr  = mshr_blk(int'(cand_addr >> OFFB));
  assign hcac[0] = cached_blk(int'(hadr[0] >> OFFB));
  assign hcac[1] = cached_blk(int'(hadr[1] >> OFFB));

  pfq_mgr #(.AW(AW), .TW(TW), .DW(DW), .CW(CW), .DEPTH(DEPTH), .BLK_BYTES(16),
            .CHECK_AT_INSERT(1'b0), .SQUASH_EN(1'b1), .DATA_ONLY(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_time(miss_time), .miss_uncache(miss_uncache), .miss_ifetch(miss_ifetch),
    .cand_valid(cand_valid), .cand_ready(crdy[0]), .cand_addr(cand_addr),
    .cand_delay(cand_delay), .cand_in_mshr(cand_in_mshr), .cand_in_cache(cand_in_cache),
    .head_addr(hadr[0]), .head_cached(hcac[0]), .issue_req(issue_req),
    .pf_valid(pfv[0]), .pf_none(pfn[0]), .pf_addr(pfa[0]),
    .bus_req(breq[0]), .bus_time(btim[0]), .ev_cnt(evc[0]));

  pfq_mgr #(.AW(AW), .TW(TW), .DW(DW), .CW(CW), .DEPTH(DEPTH), .BLK_BYTES(16),
            .CHECK_AT_INSERT(1'b1), .SQUASH_EN(1'b0), .DATA_ONLY(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_time(miss_time), .miss_uncache(miss_uncache), .miss_ifetch(miss_ifetch),
    .cand_valid(cand_valid), .cand_ready(crdy[1]), .cand_addr(cand_addr),
    .cand_delay(cand_delay), .cand_in_mshr(cand_in_mshr), .cand_in_cache(cand_in_cache),
    .head_addr(hadr[1]), .head_cached(hcac[1]), .issue_req(issue_req),
    .pf_valid(pfv[1]), .pf_none(pfn[1]), .pf_addr(pfa[1]),
    .bus_req(breq[1]), .bus_time(btim[1]), .ev_cnt(evc[1]));

  // model of both configurations: [0] issue-time check, squash, data-only
  int cfg_ins [2] = '{0, 1};
  int cfg_sq  [2] = '{1, 0};
  int cfg_do  [2] = '{1, 0};
  int mq_b [2][DEPTH];
  int mq_t [2][DEPTH];
  int mqn  [2];
  int mcnt [2][NEV];
  int mlast[2];
  int mbus [2];

  int nvec = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int c, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s dut%0d actual=%0d expected=%0d", req, c, act, exp);
    end
  endtask

  function automatic string ev_req(input int e);
    case (e)
      0: return "R10 identified";
      1: return "R6 mshr drop";
      2: return "R6/R8 cache drop";
      3: return "R6 queue dup";
      4: return "R7 evict";
      5: return "R3 miss removal";
      6: return "R4 squash";
      default: return "R8 issued";
    endcase
  endfunction

  task automatic m_del(input int c, input int idx);
    for (int k = idx; k < mqn[c] - 1; k++) begin
      mq_b[c][k] = mq_b[c][k+1];
      mq_t[c][k] = mq_t[c][k+1];
    end
    mqn[c]--;
  endtask

  task automatic m_miss(input int c, input int addr, input int t, input bit unc, input bit ifc);
    int b;
    if (unc || (ifc && cfg_do[c] != 0)) return;
    b = addr >> OFFB;
    for (int i = 0; i < mqn[c]; i++) begin
      if (mq_b[c][i] == b) begin
        m_del(c, i);
        mcnt[c][5]++;
        break;
      end
    end
    if (cfg_sq[c] != 0)
      while (mqn[c] > 0 && mq_t[c][mqn[c]-1] >= t) begin
        mqn[c]--;
        mcnt[c][6]++;
      end
    mlast[c] = t;
  endtask

  task automatic m_cand(input int c, input int addr, input int d);
    int b;
    bit dup;
    b = addr >> OFFB;
    mcnt[c][0]++;
    if (cfg_ins[c] != 0 && cached_blk(b)) begin mcnt[c][2]++; return; end
    if (mshr_blk(b)) begin mcnt[c][1]++; return; end
    dup = 0;
    for (int i = 0; i < mqn[c]; i++) if (mq_b[c][i] == b) dup = 1;
    if (dup) begin mcnt[c][3]++; return; end
    if (mqn[c] == DEPTH) begin m_del(c, 0); mcnt[c][4]++; end
    mq_b[c][mqn[c]] = b;
    mq_t[c][mqn[c]] = (mlast[c] + d) % 65536;
    mbus[c] = mq_t[c][mqn[c]];
    mqn[c]++;
  endtask

  // returns 1 and address if issued, 0 if nothing
  task automatic m_issue(input int c, output bit got, output int addr);
    got = 0;
    addr = 0;
    while (mqn[c] > 0) begin
      int b;
      b = mq_b[c][0];
      m_del(c, 0);
      if (cfg_ins[c] == 0 && cached_blk(b)) mcnt[c][2]++;
      else begin
        mcnt[c][7]++;
        got = 1;
        addr = b << OFFB;
        break;
      end
    end
  endtask

  task automatic check_all();
    for (int c = 0; c < 2; c++) begin
      for (int e = 0; e < NEV; e++)
        chk(evc[c][e] == CW'(mcnt[c][e]), ev_req(e), c, int'(evc[c][e]), mcnt[c][e]);
      chk(breq[c] == (mqn[c] != 0), "R9 bus_req", c, int'(breq[c]), int'(mqn[c] != 0));
      chk(btim[c] == TW'(mbus[c]), "R5 bus_time", c, int'(btim[c]), mbus[c]);
    end
  endtask

  // one cycle with an optional miss and an optional candidate (R11 ordering)
  task automatic apply(input bit mv, input int ma, input int mt, input bit unc, input bit ifc,
                       input bit cv, input int ca, input int cd);
    miss_valid = mv; miss_addr = AW'(ma); miss_time = TW'(mt);
    miss_uncache = unc; miss_ifetch = ifc;
    cand_valid = cv; cand_addr = AW'(ca); cand_delay = DW'(cd);
    #1;
    if (cv) for (int c = 0; c < 2; c++)
      chk(crdy[c] == 1'b1, "R11 cand_ready idle", c, int'(crdy[c]), 1);
    @(posedge clk);
    @(negedge clk);
    miss_valid = 0; cand_valid = 0;
    for (int c = 0; c < 2; c++) begin
      if (mv) m_miss(c, ma, mt, unc, ifc);
      if (cv) m_cand(c, ca, cd);
    end
    check_all();
  endtask

  task automatic do_issue(input bit mv, input int ma, input int mt);
    bit got [2];
    int ea  [2];
    bit done[2];
    bit rg  [2];
    int ra  [2];
    issue_req = 1; miss_valid = mv; miss_addr = AW'(ma); miss_time = TW'(mt);
    miss_uncache = 0; miss_ifetch = 0;
    #1;
    for (int c = 0; c < 2; c++)
      chk(crdy[c] == 1'b0, "R11 cand_ready blocked", c, int'(crdy[c]), 0);
    for (int c = 0; c < 2; c++) begin
      if (mv) m_miss(c, ma, mt, 0, 0);
      m_issue(c, got[c], ea[c]);
      done[c] = 0; rg[c] = 0; ra[c] = 0;
    end
    @(posedge clk);
    @(negedge clk);
    issue_req = 0; miss_valid = 0;
    if (mv) for (int c = 0; c < 2; c++)
      chk(!(pfv[c] || pfn[c]), "R11 issue waits on miss", c, int'(pfv[c]), 0);
    for (int n = 0; n < DEPTH + 4; n++) begin
      for (int c = 0; c < 2; c++)
        if (!done[c] && (pfv[c] || pfn[c])) begin
          done[c] = 1; rg[c] = pfv[c]; ra[c] = int'(pfa[c]);
        end
      if (done[0] && done[1]) break;
      @(posedge clk);
      @(negedge clk);
    end
    for (int c = 0; c < 2; c++) begin
      chk(done[c], "R8 issue result", c, int'(done[c]), 1);
      chk(rg[c] == got[c], "R8 issue kind", c, int'(rg[c]), int'(got[c]));
      if (got[c]) chk(ra[c] == ea[c], "R1/R8 issue address", c, ra[c], ea[c]);
    end
    check_all();
  endtask

  logic [15:0] lfsr = 16'hACE1;
  task automatic step_rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    int tcur;
    for (int c = 0; c < 2; c++) begin
      mqn[c] = 0; mlast[c] = 0; mbus[c] = 0;
      for (int e = 0; e < NEV; e++) mcnt[c][e] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk(pfv[c] == 0 && pfn[c] == 0, "R8 reset pulses", c, int'(pfv[c]), 0);
      chk(crdy[c] == 1, "R11 reset ready", c, int'(crdy[c]), 1);
    end
    check_all();
    rst_n = 1;
    @(negedge clk);

    // empty issue returns nothing
    do_issue(0, 0, 0);

    // sweep every block with varied delays: drops, dups and evictions
    for (int b = 0; b < 16; b++) apply(0, 0, 0, 0, 0, 1, b * 16 + (b % 16), b);
    for (int b = 0; b < 16; b++) apply(0, 0, 0, 0, 0, 1, b * 16 + 7, 2 * b);

    // R2: uncacheable miss on a queued block with an early time changes nothing
    apply(1, mq_b[0][mqn[0]-1] * 16 + 3, 0, 1, 0, 0, 0, 0);
    apply(1, mq_b[1][0] * 16 + 1, 0, 1, 0, 0, 0, 0);
    // R2: instruction fetch miss ignored by the data-only configuration only
    apply(1, mq_b[0][0] * 16, 1, 0, 1, 0, 0, 0);
    do_issue(0, 0, 0);

    // directed: miss and candidate on same block in one cycle (R11)
    apply(0, 0, 0, 0, 0, 1, 1 * 16, 50);
    apply(1, 1 * 16 + 5, 20, 0, 0, 1, 1 * 16 + 9, 4);
    do_issue(1, 2 * 16, 30);

    // pseudo-random sweep
    tcur = 100;
    for (int k = 0; k < 900; k++) begin
      int op, ma, ca, mt;
      step_rnd();
      op = int'(lfsr[1:0]);
      ma = int'(lfsr[15:12]) * 16 + int'(lfsr[7:4]);
      step_rnd();
      ca = int'(lfsr[11:8]) * 16 + int'(lfsr[3:0]);
      mt = tcur + int'(lfsr[14:12]) - 3;
      tcur += int'(lfsr[6:4]);
      case (op)
        0: apply(1, ma, mt, lfsr[7] & lfsr[5], lfsr[15], 0, 0, 0);
        1: apply(0, 0, 0, 0, 0, 1, ca, int'(lfsr[13:8]) % 16);
        2: apply(1, ma, mt, lfsr[7] & lfsr[5], lfsr[15], 1, ca, int'(lfsr[13:8]) % 16);
        default: do_issue(lfsr[9], ma, mt);
      endcase
    end

    // drain
    for (int k = 0; k < DEPTH + 1; k++) do_issue(0, 0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule